// File: doc/BRIEF.md
# Synthesizer Channel Word Encoder

This block turns a channel centre frequency, given in MHz, into the control word for a dual-band frequency synthesizer. It decides whether the frequency is in the 2.4 GHz band or on one of four 5 GHz rasters. Those rasters are the 5 MHz raster with a 2 MHz offset, the 20 MHz raster, the 10 MHz raster and the plain 5 MHz raster.

From that class it derives three fields: an 8-bit channel select, a 2-bit reference select and a 2.4 GHz synth mode bit. It bit-reverses the select and reference fields. It then packs all fields into a 15-bit word and hands the word out as two register payloads. It also raises a spreading flag for the one 2.4 GHz channel that needs it. A frequency that fits no rule raises an error flag instead.

A host pulses the request strobe with a frequency. One clock later the block pulses its done output. The payloads, error flag and spreading flag stay held until the next request.

The control path has two named states:
- `ST_IDLE`: no result this cycle.
- `ST_DONE`: result presented, done high.

The transitions are:
- `IDLE_TO_DONE` and `DONE_TO_DONE` are taken whenever the strobe is high.
- `DONE_TO_IDLE` and `IDLE_TO_IDLE` are taken when the strobe is low.

Top module: `chw_synth_encoder`

## Requirements
- R1: While reset is asserted and after it is released, done, error, spread and both payloads are 0 until the first request.
- R2: Done is high in exactly the cycle after each cycle in which the strobe is sampled high, and low otherwise. Back-to-back strobes give back-to-back results.
- R3: For f < 4800 with f mod 5 = 2, the raw select is ((f−672)·2−3040)/10, the mode bit is 0 and the reference field is 0. The select field is reverse8((raw·4) mod 256).
- R4: For f < 4800 with f mod 5 = 4, the raw select is ((f−704)·2−3040)/10, the mode bit is 1 and the reference field is 0. The select field is reverse8((raw·4) mod 256).
- R5: The spread output is 1 exactly when the last request was 2484 MHz, and 0 for every other request.
- R6: For f ≥ 4800 with f mod 5 = 2 and f ≤ 5435, let g = f−2. The select field is reverse8(((g−4800)·10)/25+1) and the reference field is 0.
- R7: Otherwise, for f mod 20 = 0 and f ≥ 5120, the select field is reverse8(((f−4800)/20)·4 mod 256) and the reference field is 3 (binary 11).
- R8: Otherwise, for f mod 10 = 0, the select field is reverse8(((f−4800)/10)·2 mod 256) and the reference field is 1 (reverse2 of 2).
- R9: Otherwise, for f mod 5 = 0, the select field is reverse8((f−4800)/5 mod 256) and the reference field is 2 (reverse2 of 1).
- R10: Any other frequency sets error to 1, with both payloads and spread at 0. For example: f < 4800 with f mod 5 in {0,1,3}, or f ≥ 4800 matching no 5 GHz rule.
- R11: The word is bit 0 = 1, bit 1 = mode, bits 3:2 = reference field, bits 11:4 = select field, bit 12 = 1 and bits 14:13 = 0. The low payload is word bits 7:0 and the high payload is word bits 14:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; frequency is captured on this cycle |
| req_freq | input | 16 | Channel centre frequency in MHz |
| rsp_done | output | 1 | One-cycle pulse marking a new result |
| rsp_err | output | 1 | Last request matched no raster rule |
| rsp_spread | output | 1 | Last request was the 2484 MHz channel |
| rsp_lo | output | 8 | Low payload, word bits 7:0 |
| rsp_hi | output | 7 | High payload, word bits 14:8 |

## Verification
The bench sweeps both bands one megahertz at a time across their raster boundaries. It also hits specific edges:
- the 5435/5437 limit of the offset raster;
- 5100 against 5120, where a 20 MHz-aligned frequency must fall back to the 10 MHz rule;
- 4800 itself;
- frequencies below 2192, where the 2.4 GHz select goes negative and only its low bits survive;
- 0 and the top of the 16-bit range.

A design with the raster tests in the wrong priority would put 5100 on the 20 MHz rule with reference 3. A design with a wrong division constant or a missing wrap would give off-by-one or saturated selects. A design that swapped the reversed reference codes would show 2 for the 10 MHz raster. Checks every cycle of done, spread and the zeroed payloads catch latency slips, a flag left stale across requests, and error results that leak a partial word.

// File: rtl/chw_pkg.sv
package chw_pkg;
    localparam int FREQ_W = 16;
    localparam int SEL_W  = 8;
    localparam int REF_W  = 2;
    localparam int WORD_W = 15;
    localparam int LO_W   = 8;
    localparam int HI_W   = WORD_W - LO_W;
    localparam int Q5_W   = 14;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_LOW_A,
        CLS_LOW_B,
        CLS_ODD,
        CLS_R20,
        CLS_R10,
        CLS_R5
    } raster_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } ctl_state_e;
endpackage

// File: rtl/chw_div5.sv
module chw_div5
    import chw_pkg::*;
(
    input  logic [FREQ_W-1:0] f,
    output logic [Q5_W-1:0]   q,
    output logic [2:0]        r
);
    localparam int          SHIFT = FREQ_W + 2;
    localparam logic [17:0] MAGIC = 18'd52429;
    localparam int          PW    = FREQ_W + 18;

    logic [PW-1:0]     prod;
    logic [FREQ_W-1:0] back;

    always_comb begin
        prod = PW'(f) * PW'(MAGIC);
        q    = Q5_W'(prod >> SHIFT);
        back = FREQ_W'(q) * FREQ_W'(5);
        r    = 3'(f - back);
    end
endmodule

// File: rtl/chw_classify.sv
module chw_classify
    import chw_pkg::*;
(
    input  logic [FREQ_W-1:0] f,
    input  logic [Q5_W-1:0]   q5,
    input  logic [2:0]        r5,
    output raster_e           cls,
    output logic [SEL_W-1:0]  sel_raw,
    output logic [REF_W-1:0]  ref_raw,
    output logic              mode
);
    localparam logic [FREQ_W-1:0] LOW_TOP  = 16'd4800;
    localparam logic [FREQ_W-1:0] ODD_TOP  = 16'd5435;
    localparam logic [FREQ_W-1:0] R20_BASE = 16'd5120;

    logic [Q5_W-1:0] t;

    always_comb begin
        cls     = CLS_NONE;
        sel_raw = '0;
        ref_raw = '0;
        mode    = 1'b0;
        t       = '0;
        if (f < LOW_TOP) begin
            if (r5 == 3'd2) begin
                cls     = CLS_LOW_A;
                t       = q5 - Q5_W'(438);
                sel_raw = {t[5:0], 2'b00};
            end else if (r5 == 3'd4) begin
                cls     = CLS_LOW_B;
                t       = q5 - Q5_W'(444);
                sel_raw = {t[5:0], 2'b00};
                mode    = 1'b1;
            end
        end else if (r5 == 3'd2 && f <= ODD_TOP) begin
            cls     = CLS_ODD;
            t       = q5 - Q5_W'(960);
            sel_raw = {t[6:0], 1'b1};
        end else if (r5 == 3'd0 && q5[1:0] == 2'b00 && f >= R20_BASE) begin
            cls     = CLS_R20;
            t       = (q5 >> 2) - Q5_W'(240);
            sel_raw = {t[5:0], 2'b00};
            ref_raw = 2'd3;
        end else if (r5 == 3'd0 && !q5[0]) begin
            cls     = CLS_R10;
            t       = (q5 >> 1) - Q5_W'(480);
            sel_raw = {t[6:0], 1'b0};
            ref_raw = 2'd2;
        end else if (r5 == 3'd0) begin
            cls     = CLS_R5;
            t       = q5 - Q5_W'(960);
            sel_raw = t[7:0];
            ref_raw = 2'd1;
        end
    end
endmodule

// File: rtl/chw_assemble.sv
module chw_assemble
    import chw_pkg::*;
(
    input  raster_e          cls,
    input  logic [SEL_W-1:0] sel_raw,
    input  logic [REF_W-1:0] ref_raw,
    input  logic             mode,
    output logic             err,
    output logic [WORD_W-1:0] word
);
    logic [SEL_W-1:0] sel_rev;
    logic [REF_W-1:0] ref_rev;

    for (genvar i = 0; i < SEL_W; i++) begin : g_sel_rev
        assign sel_rev[i] = sel_raw[SEL_W-1-i];
    end
    for (genvar j = 0; j < REF_W; j++) begin : g_ref_rev
        assign ref_rev[j] = ref_raw[REF_W-1-j];
    end

    always_comb begin
        err  = (cls == CLS_NONE);
        word = '0;
        if (!err) begin
            word[0]     = 1'b1;
            word[1]     = mode;
            word[3:2]   = ref_rev;
            word[11:4]  = sel_rev;
            word[12]    = 1'b1;
        end
    end
endmodule

// File: rtl/chw_synth_encoder.sv
module chw_synth_encoder
    import chw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [FREQ_W-1:0] req_freq,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              rsp_spread,
    output logic [LO_W-1:0]   rsp_lo,
    output logic [HI_W-1:0]   rsp_hi
);
    localparam logic [FREQ_W-1:0] SPREAD_FREQ = 16'd2484;

    ctl_state_e        state, state_nx;
    logic [Q5_W-1:0]   q5;
    logic [2:0]        r5;
    raster_e           cls;
    logic [SEL_W-1:0]  sel_raw;
    logic [REF_W-1:0]  ref_raw;
    logic              mode;
    logic              err_c;
    logic [WORD_W-1:0] word_c;

    chw_div5 u_div5 (.f(req_freq), .q(q5), .r(r5));

    chw_classify u_cls (
        .f(req_freq), .q5(q5), .r5(r5), .cls(cls),
        .sel_raw(sel_raw), .ref_raw(ref_raw), .mode(mode)
    );

    chw_assemble u_asm (
        .cls(cls), .sel_raw(sel_raw), .ref_raw(ref_raw), .mode(mode),
        .err(err_c), .word(word_c)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_err    <= 1'b0;
            rsp_spread <= 1'b0;
            rsp_lo     <= '0;
            rsp_hi     <= '0;
        end else if (req_valid) begin
            rsp_err    <= err_c;
            rsp_spread <= (cls == CLS_LOW_B) && (req_freq == SPREAD_FREQ);
            rsp_lo     <= word_c[LO_W-1:0];
            rsp_hi     <= word_c[WORD_W-1:LO_W];
        end
    end

    assign rsp_done = (state == ST_DONE);

    // R2
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);
    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(req_valid));
    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_lo == '0 && rsp_hi == '0 && !rsp_spread));
    // R11
    marker_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> (rsp_lo[0] && rsp_hi[4] && rsp_hi[6:5] == 2'b00));
    // R5
    spread_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_spread) |-> ($past(req_freq) == SPREAD_FREQ));
endmodule

// File: tb/test_chw_synth_encoder.sv
module test_chw_synth_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_freq = '0;
    logic        rsp_done, rsp_err, rsp_spread;
    logic [7:0]  rsp_lo;
    logic [6:0]  rsp_hi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 1'b0;

    logic        e_done = 1'b0, e_err = 1'b0, e_spread = 1'b0;
    logic [7:0]  e_lo = '0;
    logic [6:0]  e_hi = '0;
    string       e_tag = "R1";

    chw_synth_encoder i_chw_synth_encoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_spread(rsp_spread),
        .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
    );

    always #2 clk = ~clk;

    function automatic int rev(input int v, input int n);
        int o = 0;
        for (int i = 0; i < n; i++) if ((v >> i) & 1) o |= 1 << (n - 1 - i);
        return o;
    endfunction

    task automatic model(input int f, output bit err, output bit spr,
                         output int lo, output int hi, output string tag);
        int sel = 0, rf = 0, md = 0, w;
        err = 0; spr = 0; tag = "R10";
        if (f < 4800) begin
            if ((f - 2192) % 5 == 0) begin
                sel = ((f - 672) * 2 - 3040) / 10; tag = "R3";
            end else if ((f - 2224) % 5 == 0) begin
                sel = ((f - 704) * 2 - 3040) / 10; md = 1; tag = "R4";
            end else err = 1;
            sel = rev((sel << 2) & 255, 8);
            spr = !err && f == 2484;
            if (spr) tag = "R5";
        end else if (f % 5 == 2 && f <= 5435) begin
            sel = rev((((f - 2 - 4800) * 10) / 25 + 1) & 255, 8); rf = 0; tag = "R6";
        end else if (f % 20 == 0 && f >= 5120) begin
            sel = rev((((f - 4800) / 20) << 2) & 255, 8); rf = rev(3, 2); tag = "R7";
        end else if (f % 10 == 0) begin
            sel = rev((((f - 4800) / 10) << 1) & 255, 8); rf = rev(2, 2); tag = "R8";
        end else if (f % 5 == 0) begin
            sel = rev(((f - 4800) / 5) & 255, 8); rf = rev(1, 2); tag = "R9";
        end else err = 1;
        w = (sel << 4) | (rf << 2) | (md << 1) | (1 << 12) | 1;
        lo = err ? 0 : (w & 255);
        hi = err ? 0 : ((w >> 8) & 127);
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            e_done <= 0; e_err <= 0; e_spread <= 0; e_lo <= 0; e_hi <= 0; e_tag <= "R1";
        end else begin
            e_done <= req_valid;
            if (req_valid) begin
                bit er, sp; int l, h; string t;
                model(int'(req_freq), er, sp, l, h, t);
                e_err <= er; e_spread <= sp; e_lo <= 8'(l); e_hi <= 7'(h); e_tag <= t;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (rsp_done !== e_done) begin
                errors++;
                $display("FAIL R2 done actual %0b expected %0b", rsp_done, e_done);
            end else if (rsp_err !== e_err || rsp_lo !== e_lo || rsp_hi !== e_hi) begin
                errors++;
                $display("FAIL %s err/lo/hi actual %0b/%h/%h expected %0b/%h/%h",
                         e_tag, rsp_err, rsp_lo, rsp_hi, e_err, e_lo, e_hi);
            end else if (rsp_spread !== e_spread) begin
                errors++;
                $display("FAIL R5 spread actual %0b expected %0b", rsp_spread, e_spread);
            end
            if (rsp_done && !e_err) begin
                checks++;
                if (rsp_lo[0] !== 1'b1 || rsp_hi[4] !== 1'b1) begin
                    errors++;
                    $display("FAIL R11 marker bits actual %0b%0b expected 11", rsp_hi[4], rsp_lo[0]);
                end
            end
        end
    end

    task automatic send(input int f, input int gap);
        @(negedge clk);
        req_valid = 1'b1; req_freq = 16'(f);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < gap; k++) @(negedge clk);
    endtask

    initial begin
        int corner[$] = '{2412, 2417, 2437, 2462, 2472, 2484, 2414, 2413, 2192, 100, 0,
                           4800, 4801, 4802, 5432, 5435, 5437, 5100, 5120, 5170, 5180,
                           5165, 5745, 5500, 65535, 65520, 65532};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        foreach (corner[i]) send(corner[i], 1);
        for (int f = 2150; f <= 2500; f++) begin
            @(negedge clk); req_valid = 1'b1; req_freq = 16'(f);
        end
        for (int f = 4780; f <= 5920; f++) begin
            @(negedge clk); req_valid = 1'b1; req_freq = 16'(f);
        end
        @(negedge clk); req_valid = 1'b0;
        send(2484, 0);
        send(2412, 3);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule